// File: doc/BRIEF.md
# NAND Device Geometry Probe

This block interrogates a single parallel NAND device and reports how its array is organised. A one-cycle start pulse makes it select the device and clock in the identify command and one zero address byte. It then clocks out two bytes. The first byte (the manufacturer code) is thrown away. The second byte (the device code) is matched against seven built-in codes. A hit yields the page size, the pages per erase block and the number of blocks, and raises a valid flag. A miss raises an error flag and leaves the geometry at zero.

The pin side is a plain 8-bit bus with an active-low chip enable, command and address latch enables, and active-low write and read strobes. The strobe-low time and the recovery time after each strobe are set in clock cycles by parameters, so the block can be fitted to the device timing at any system clock. A one-cycle done pulse marks the end of a probe. Typical use is once after power-up, before any page access logic is configured.

Top module: `nand_id_probe`

## Requirements
- R1: While reset is held and after it: chip enable (active low) is high, both latch enables are low, both strobes are high, the bus driver is off, and busy, done, valid and error are all low.
- R2: A probe performs exactly two bus writes and then two bus reads, in this order. The first write carries byte 0x90 with the command latch enable high and the address latch enable low. The second carries 0x00 with the address latch enable high and the command latch enable low. The two latch enables are never high together.
- R3: For each written byte, the bus driver is on and the byte is presented for exactly SETUP_CYC cycles with the write strobe low. The driver then stays on with the byte unchanged for exactly HOLD_CYC cycles after the write strobe rises.
- R4: Each read holds the read strobe low for exactly SETUP_CYC cycles. The bus is sampled in the last low cycle. The first byte read is ignored and only the second is decoded.
- R5: Device code 0xEA gives 256-byte pages, 16 pages per block and 512 blocks. Codes 0xE3 and 0xE5 give 512, 16 and 512. Code 0xE6 gives 512, 16 and 1024.
- R6: Device codes 0x73, 0x75 and 0x76 give 512-byte pages and 32 pages per block, with 1024, 2048 and 4096 blocks respectively. The block count is a multiplier of 1, 2, 4 or 8 shifted left by 9.
- R7: Any other device code gives error high, valid low, and page size, pages per block and block count all zero. Valid and error are never high together.
- R8: Chip enable goes high in the same cycle as the one-cycle done pulse, right after the second read. Busy is low and the result outputs are final in that cycle.
- R9: Valid and error keep their values after done until a new start is accepted. Both clear in the cycle after that start.
- R10: A start pulse that arrives while a probe is running has no effect: that probe still performs exactly two writes and two reads, and no further probe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a probe |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| dq_o | output | 8 | Byte driven toward the device |
| dq_oe_o | output | 1 | Bus driver enable |
| dq_i | input | 8 | Byte returned by the device |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| geo_valid_o | output | 1 | Device code recognised |
| id_err_o | output | 1 | Device code not recognised |
| page_bytes_o | output | 10 | Page data size in bytes |
| pages_per_blk_o | output | 6 | Pages per erase block |
| blk_count_o | output | 13 | Number of erase blocks |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a running probe. The bench raises start again a few cycles after the first one, while the address byte is on the bus. It then counts every strobe edge until done and for several idle cycles after it, to show that no second sequence began. The maker-byte case is also set up with care. The modelled device returns a maker byte that is itself a valid device code, and a different device code, so decoding the wrong byte would give visibly different geometry.

// File: rtl/nid_pkg.sv
// Package: shared constants and the decoded-code record for the NAND
// geometry probe. Assumes an 8-bit device bus.
package nid_pkg;
    localparam int DQ_W = 8;
    localparam logic [DQ_W-1:0] CMD_IDENTIFY = 8'h90;
    localparam logic [DQ_W-1:0] ADDR_FIRST   = 8'h00;
    localparam int BLK_SHIFT = 9;

    typedef struct packed {
        logic       hit;       // code found in table
        logic       big_page;  // 1: 512-byte pages, 0: 256-byte pages
        logic [5:0] ppb;       // pages per block
        logic [3:0] blk_mult;  // block count >> BLK_SHIFT
    } geo_code_t;
endpackage

// File: rtl/nid_bus_cycle.sv
// Module: runs one byte transfer on the device bus. A write drives the byte
// with the write strobe low for SETUP_CYC cycles and keeps it driven for
// HOLD_CYC cycles after the strobe rises. A read holds the read strobe low
// for SETUP_CYC cycles and samples in the last of them.
// Assumes: go is raised only while idle_o is high; SETUP_CYC, HOLD_CYC >= 1.
module nid_bus_cycle
    import nid_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            is_read,
    input  logic [DQ_W-1:0] wdata,
    input  logic [DQ_W-1:0] dq_i,
    output logic            we_n,
    output logic            re_n,
    output logic            dq_oe,
    output logic [DQ_W-1:0] dq_o,
    output logic [DQ_W-1:0] rdata,
    output logic            fin,
    output logic            idle_o
);
    localparam int MAXC  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(HOLD_CYC - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_REC} phase_t;

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             rd_mode;
    logic [DQ_W-1:0]  wbyte;

    // Phase sequencing, cycle counting and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            rd_mode <= 1'b0;
            wbyte   <= '0;
            rdata   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go) begin
                    phase   <= PH_ACT;
                    cnt     <= '0;
                    rd_mode <= is_read;
                    wbyte   <= wdata;
                end
                PH_ACT: if (cnt == ACT_LAST) begin
                    phase <= PH_REC;
                    cnt   <= '0;
                    if (rd_mode) rdata <= dq_i;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_REC: if (cnt == REC_LAST) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin and handshake decode from the current phase.
    always_comb begin
        we_n   = !(phase == PH_ACT && !rd_mode);
        re_n   = !(phase == PH_ACT &&  rd_mode);
        dq_oe  = (phase != PH_IDLE) && !rd_mode;
        dq_o   = wbyte;
        fin    = (phase == PH_REC) && (cnt == REC_LAST);
        idle_o = (phase == PH_IDLE);
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R3
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_o));
    // R10
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> idle_o);
endmodule

// File: rtl/nid_code_lookup.sv
// Module: combinational match of a device code against the seven supported
// parts. Assumes the caller zeroes outputs itself on a miss.
module nid_code_lookup
    import nid_pkg::*;
(
    input  logic [DQ_W-1:0] code,
    output geo_code_t       geo
);
    // Table match: page class, pages per block, block multiplier.
    always_comb begin
        geo = '{hit: 1'b1, big_page: 1'b1, ppb: 6'd16, blk_mult: 4'd1};
        case (code)
            8'hEA: geo.big_page = 1'b0;
            8'hE3, 8'hE5: ;
            8'hE6: geo.blk_mult = 4'd2;
            8'h73: begin geo.ppb = 6'd32; geo.blk_mult = 4'd2; end
            8'h75: begin geo.ppb = 6'd32; geo.blk_mult = 4'd4; end
            8'h76: begin geo.ppb = 6'd32; geo.blk_mult = 4'd8; end
            default: geo = '0;
        endcase
    end
endmodule

// File: rtl/nand_id_probe.sv
// Module: top of the NAND geometry probe. It sequences the command byte, the
// address byte and two reads, decodes the second byte and holds the result.
// Assumes one device on one chip enable and a one-cycle start pulse.
module nand_id_probe
    import nid_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        ce_n_o,
    output logic        cle_o,
    output logic        ale_o,
    output logic        we_n_o,
    output logic        re_n_o,
    output logic [7:0]  dq_o,
    output logic        dq_oe_o,
    input  logic [7:0]  dq_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        geo_valid_o,
    output logic        id_err_o,
    output logic [9:0]  page_bytes_o,
    output logic [5:0]  pages_per_blk_o,
    output logic [12:0] blk_count_o
);
    typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_ADR, ST_RD_MK, ST_RD_DEV} st_t;

    st_t             state;
    logic            issued;
    logic            go, is_read, fin, unit_idle;
    logic [DQ_W-1:0] wdata, rbyte;
    geo_code_t       geo;

    // Byte launch control for the current step.
    always_comb begin
        go      = (state != ST_IDLE) && !issued;
        is_read = (state == ST_RD_MK) || (state == ST_RD_DEV);
        wdata   = (state == ST_CMD) ? CMD_IDENTIFY : ADDR_FIRST;
    end

    nid_bus_cycle #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_cycle (
        .clk(clk), .rst_n(rst_n), .go(go), .is_read(is_read), .wdata(wdata),
        .dq_i(dq_i), .we_n(we_n_o), .re_n(re_n_o), .dq_oe(dq_oe_o),
        .dq_o(dq_o), .rdata(rbyte), .fin(fin), .idle_o(unit_idle)
    );

    nid_code_lookup u_lookup (.code(rbyte), .geo(geo));

    // Probe sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            issued          <= 1'b0;
            done_o          <= 1'b0;
            geo_valid_o     <= 1'b0;
            id_err_o        <= 1'b0;
            page_bytes_o    <= '0;
            pages_per_blk_o <= '0;
            blk_count_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (state == ST_IDLE) begin
                if (start_i) begin
                    state       <= ST_CMD;
                    issued      <= 1'b0;
                    geo_valid_o <= 1'b0;
                    id_err_o    <= 1'b0;
                end
            end else if (fin) begin
                issued <= 1'b0;
                case (state)
                    ST_CMD:   state <= ST_ADR;
                    ST_ADR:   state <= ST_RD_MK;
                    ST_RD_MK: state <= ST_RD_DEV;
                    default: begin
                        state           <= ST_IDLE;
                        done_o          <= 1'b1;
                        geo_valid_o     <= geo.hit;
                        id_err_o        <= !geo.hit;
                        page_bytes_o    <= !geo.hit ? 10'd0 : (geo.big_page ? 10'd512 : 10'd256);
                        pages_per_blk_o <= geo.ppb;
                        blk_count_o     <= 13'(geo.blk_mult) << BLK_SHIFT;
                    end
                endcase
            end else if (go) begin
                issued <= 1'b1;
            end
        end
    end

    // Chip-side control levels follow the step.
    always_comb begin
        ce_n_o = (state == ST_IDLE);
        cle_o  = (state == ST_CMD);
        ale_o  = (state == ST_ADR);
        busy_o = (state != ST_IDLE);
    end

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));
    // R8
    done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ce_n_o && !busy_o));
    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(geo_valid_o && id_err_o));
    // R9
    valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid_o && !start_i) |=> geo_valid_o);
    // R8
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));
endmodule

// File: tb/sim_nand_id_probe.sv
module sim_nand_id_probe;
    localparam int SU = 3;
    localparam int HD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ce_n_o, cle_o, ale_o, we_n_o, re_n_o, dq_oe_o;
    logic busy_o, done_o, geo_valid_o, id_err_o;
    logic [7:0] dq_o, dq_i;
    logic [9:0] page_bytes_o;
    logic [5:0] pages_per_blk_o;
    logic [12:0] blk_count_o;

    always #2.5 clk = ~clk;

    nand_id_probe #(.SETUP_CYC(SU), .HOLD_CYC(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ce_n_o(ce_n_o),
        .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o), .re_n_o(re_n_o),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i), .busy_o(busy_o),
        .done_o(done_o), .geo_valid_o(geo_valid_o), .id_err_o(id_err_o),
        .page_bytes_o(page_bytes_o), .pages_per_blk_o(pages_per_blk_o),
        .blk_count_o(blk_count_o)
    );

    int checks = 0;
    int errors = 0;

    // Device model: maker byte first, device byte afterwards.
    logic [7:0] maker = 8'hEA;
    logic [7:0] dev_code = 8'h00;
    int rd_cnt = 0;
    assign dq_i = (rd_cnt == 0) ? maker : dev_code;

    // Bus monitor, sampled mid-cycle.
    int wr_cnt = 0, we_run = 0, re_run = 0, hold_run = 0, both_hi = 0, ce_bad = 0;
    logic [7:0] wr_data [4];
    logic       wr_cle [4], wr_ale [4];
    int         wr_su [4], wr_hd [4], rd_len [4];
    logic prev_we = 1'b1, prev_re = 1'b1, prev_hold = 1'b0;

    always @(negedge clk) begin
        if (cle_o === 1'b1 && ale_o === 1'b1) both_hi++;
        if (we_n_o === 1'b0) begin
            we_run++;
            if (ce_n_o !== 1'b0 || dq_oe_o !== 1'b1) ce_bad++;
        end
        if (re_n_o === 1'b0) begin
            re_run++;
            if (ce_n_o !== 1'b0) ce_bad++;
        end
        if (prev_we == 1'b0 && we_n_o === 1'b1 && wr_cnt < 4) begin
            wr_data[wr_cnt] = dq_o; wr_cle[wr_cnt] = cle_o;
            wr_ale[wr_cnt] = ale_o; wr_su[wr_cnt] = we_run;
            wr_cnt++; we_run = 0;
        end
        if (we_n_o === 1'b1 && dq_oe_o === 1'b1) hold_run++;
        else if (prev_hold && wr_cnt > 0) begin
            wr_hd[wr_cnt-1] = hold_run; hold_run = 0;
        end
        prev_hold = (we_n_o === 1'b1 && dq_oe_o === 1'b1);
        if (prev_re == 1'b0 && re_n_o === 1'b1 && rd_cnt < 4) begin
            rd_len[rd_cnt] = re_run; rd_cnt++; re_run = 0;
        end
        prev_we = (we_n_o === 1'b0) ? 1'b0 : 1'b1;
        prev_re = (re_n_o === 1'b0) ? 1'b0 : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wr_cnt = 0; rd_cnt = 0; both_hi = 0; ce_bad = 0;
        for (int i = 0; i < 4; i++) begin wr_su[i] = 0; wr_hd[i] = 0; rd_len[i] = 0; end
    endtask

    // Pulse start and wait for done; returns 1 if done was seen.
    task automatic run_probe(input logic [7:0] dev, input int restart_at, output bit seen);
        int n;
        clear_log();
        dev_code = dev;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 0;
        while (done_o !== 1'b1 && n < 500) begin
            if (n == restart_at) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        seen = (done_o === 1'b1);
    endtask

    task automatic t_reset();
        chk(ce_n_o === 1 && cle_o === 0 && ale_o === 0, "R1 latch/ce", {cle_o, ale_o, ce_n_o}, 1);
        chk(we_n_o === 1 && re_n_o === 1 && dq_oe_o === 0, "R1 strobes", {we_n_o, re_n_o, dq_oe_o}, 6);
        chk(busy_o === 0 && done_o === 0 && geo_valid_o === 0 && id_err_o === 0, "R1 flags",
            {busy_o, done_o, geo_valid_o, id_err_o}, 0);
    endtask

    task automatic t_known(input logic [7:0] dev, input int pb, input int ppb, input int blks,
                           input string req);
        bit seen;
        run_probe(dev, -1, seen);
        chk(seen, "R8 done seen", seen, 1);
        chk(ce_n_o === 1 && busy_o === 0, "R8 ce high at done", {ce_n_o, busy_o}, 2);
        chk(geo_valid_o === 1 && id_err_o === 0, {req, " valid"}, {geo_valid_o, id_err_o}, 2);
        chk(page_bytes_o == pb, {req, " page bytes"}, page_bytes_o, pb);
        chk(pages_per_blk_o == ppb, {req, " pages/blk"}, pages_per_blk_o, ppb);
        chk(blk_count_o == blks, {req, " blocks"}, blk_count_o, blks);
        chk(wr_cnt == 2 && rd_cnt == 2, "R2 transfer count", wr_cnt * 10 + rd_cnt, 22);
        chk(wr_data[0] == 8'h90 && wr_cle[0] && !wr_ale[0], "R2 command byte", wr_data[0], 'h90);
        chk(wr_data[1] == 8'h00 && !wr_cle[1] && wr_ale[1], "R2 address byte", wr_data[1], 0);
        chk(both_hi == 0 && ce_bad == 0, "R2 latch overlap / ce", both_hi + ce_bad, 0);
        chk(wr_su[0] == SU && wr_su[1] == SU, "R3 setup", wr_su[0] * 10 + wr_su[1], SU * 11);
        chk(wr_hd[0] == HD && wr_hd[1] == HD, "R3 hold", wr_hd[0] * 10 + wr_hd[1], HD * 11);
        chk(rd_len[0] == SU && rd_len[1] == SU, "R4 read strobe", rd_len[0] * 10 + rd_len[1], SU * 11);
        @(negedge clk);
        chk(done_o === 0 && geo_valid_o === 1, "R9 valid kept, done one cycle",
            {done_o, geo_valid_o}, 1);
    endtask

    task automatic t_unknown(input logic [7:0] dev);
        bit seen;
        run_probe(dev, -1, seen);
        chk(seen && id_err_o === 1 && geo_valid_o === 0, "R7 unknown flags",
            {geo_valid_o, id_err_o}, 1);
        chk(page_bytes_o == 0 && pages_per_blk_o == 0 && blk_count_o == 0, "R7 geometry zero",
            page_bytes_o + pages_per_blk_o + blk_count_o, 0);
    endtask

    task automatic t_restart_clears();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(geo_valid_o === 0 && id_err_o === 0 && busy_o === 1, "R9 cleared by start",
            {busy_o, geo_valid_o, id_err_o}, 4);
        while (done_o !== 1'b1) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        bit seen;
        run_probe(8'hE6, 8, seen);
        chk(seen && wr_cnt == 2 && rd_cnt == 2, "R10 one sequence", wr_cnt * 10 + rd_cnt, 22);
        chk(blk_count_o == 1024, "R10 result intact", blk_count_o, 1024);
        repeat (30) @(negedge clk);
        chk(busy_o === 0 && wr_cnt == 2 && ce_n_o === 1, "R10 no second probe", wr_cnt, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        maker = 8'h76;                    // valid code in maker slot (R4)
        t_known(8'hEA, 256, 16, 512,  "R5 EA");
        maker = 8'hEA;
        t_known(8'hE3, 512, 16, 512,  "R5 E3");
        t_known(8'hE5, 512, 16, 512,  "R5 E5");
        t_known(8'hE6, 512, 16, 1024, "R5 E6");
        t_known(8'h73, 512, 32, 1024, "R6 73");
        t_known(8'h75, 512, 32, 2048, "R6 75");
        t_known(8'h76, 512, 32, 4096, "R4 R6 76 maker ignored");
        t_restart_clears();
        t_unknown(8'hE4);
        t_unknown(8'h90);
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule